// File: doc/BRIEF.md
# Chained Watchdog Timer Pair

This block holds a small bank of down-counters behind a simple register bus. The counters are 64 bits wide by default. One counter, the second by default, can take the watchdog role. When it runs out while it holds that role, the block pulses a reset request for one cycle. The watchdog is never refreshed by writing a magic value. It runs in hardware-triggered mode and restarts whenever its lower neighbour signals end of count. That neighbour is a one-shot counter loaded with zero, so turning its enable off and then on again produces one fresh end-of-count event. That event is the refresh.

Each counter divides the clock with its own prescaler and counts down once per prescale period. A read-only active flag is set while the counter runs. While that flag is set, the mode, trigger and prescale fields cannot be written.

Top module: `wdt_chain_timer`

## Requirements
- R1: Counter i is mapped at byte address i*0x10.
  - Its control word is at +0x0.
  - Count bits [31:0] are at +0x4 and count bits [63:32] are at +0x8.
  - A count write sets the reload value. A count read returns the live count.
  - The role select word is at 0x20. Its bit i gives counter i the watchdog role. Other addresses read 0.
- R2: Control word fields:
  - bit 0 is enable (read/write)
  - bit 1 is active (read-only)
  - bits [3:2] are the mode
  - bits [7:4] are the trigger source
  - bits [15:8] are the prescale value
  - All registers reset to 0.
- R3: Mode 00 is one-shot. Mode values 01 and 10 behave the same way.
  - Writing enable from 0 to 1 loads the reload value and sets active.
  - On each prescale tick the count drops by 1. At a tick where the count is already 0, the counter signals end of count and clears active.
- R4: A tick occurs every P clocks, where P is the prescale value, raised to 2 if below 2. The first tick is P clocks after the start edge. A counter started with reload N therefore ends P*(N+1) clocks after it starts.
- R5: Mode 11 is hardware-triggered. Setting enable does not start the counter. While enabled, each trigger event reloads the count, restarts the prescaler and sets active, even if the counter is already running.
- R6: Trigger source value 5 selects the end-of-count event of counter i-1. Any other trigger source value, and value 5 on counter 0, never triggers.
- R7: A control write with enable 0 clears active at that edge and freezes the live count.
- R8: A control write while active changes only the enable bit. Mode, trigger source and prescale keep their values.
- R9: When the watchdog counter reaches end of count while its role bit is set, the reset request output is high for exactly the one following cycle. With the role bit clear, no request is made.
- R10: Toggling counter 0's enable (with reload 0, one-shot mode) restarts the chained watchdog counter. Refreshing more often than the watchdog period never raises a reset request.
- R11: A watchdog reload value of 0 expires at the first tick after the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 6 | Byte address for both write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
Most wrong internal states show at rst_req. A prescaler that is off by one, a missed reload, or a trigger that is dropped moves or removes the reset pulse by at least one prescale period. The reference model compares rst_req on every clock, so such a fault is caught within one watchdog period. Errors in the live count, the active flag or the locked configuration fields appear on bus_rdata as soon as the affected address is read. The bench reads those addresses at cycles where the count is known exactly.

// File: rtl/wdt_chain_pkg.sv
`timescale 1ns/1ps
package wdt_chain_pkg;

  localparam logic [1:0] MODE_ONESHOT = 2'b00;
  localparam logic [1:0] MODE_HWTRIG  = 2'b11;
  localparam logic [3:0] TRIG_PREV    = 4'h5;
  localparam logic [7:0] PRESC_MIN    = 8'd2;

  typedef struct packed {
    logic [7:0] presc;
    logic [3:0] trig;
    logic [1:0] mode;
  } cnt_cfg_t;

  // Clocks per tick: prescale value, but never below the minimum.
  function automatic logic [7:0] eff_presc(input logic [7:0] p);
    return (p < PRESC_MIN) ? PRESC_MIN : p;
  endfunction

  // Control word image as seen on the bus.
  function automatic logic [31:0] ctrl_image(input cnt_cfg_t c, input logic act, input logic en);
    return {16'h0000, c, act, en};
  endfunction

endpackage

// File: rtl/wdt_counter.sv
`timescale 1ns/1ps
module wdt_counter
  import wdt_chain_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [15:0]      ctrl_wdata,
  input  logic             lo_we,
  input  logic             hi_we,
  input  logic [31:0]      word_wdata,
  input  logic             prev_end,
  output cnt_cfg_t         cfg,
  output logic             en,
  output logic             active,
  output logic [CNT_W-1:0] live,
  output logic [CNT_W-1:0] reload,
  output logic             end_evt,
  output logic             trig_hit
);

  localparam int HI_W = CNT_W - 32;

  logic [7:0] pre_cnt;
  logic       tick, start, stop;
  cnt_cfg_t   cfg_nxt, cfg_wr;
  logic       unused_ro_bit;

  assign unused_ro_bit = ctrl_wdata[1];
  assign cfg_wr   = cnt_cfg_t'({ctrl_wdata[15:2]});
  assign cfg_nxt  = (ctrl_we && !active) ? cfg_wr : cfg;

  assign tick     = active && (pre_cnt == eff_presc(cfg.presc) - 8'd1);
  assign end_evt  = tick && (live == '0);
  assign trig_hit = en && (cfg.mode == MODE_HWTRIG) && (cfg.trig == TRIG_PREV) && prev_end;
  assign stop     = ctrl_we && !ctrl_wdata[0];
  assign start    = (ctrl_we && ctrl_wdata[0] && !en && (cfg_nxt.mode != MODE_HWTRIG)) || trig_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg     <= '0;
      en      <= 1'b0;
      active  <= 1'b0;
      live    <= '0;
      reload  <= '0;
      pre_cnt <= '0;
    end else begin
      if (ctrl_we) begin
        en  <= ctrl_wdata[0];
        cfg <= cfg_nxt;
      end
      if (lo_we) reload[31:0]      <= word_wdata;
      if (hi_we) reload[CNT_W-1:32] <= word_wdata[HI_W-1:0];

      if (stop) begin
        active <= 1'b0;
      end else if (start) begin
        active  <= 1'b1;
        live    <= reload;
        pre_cnt <= '0;
      end else if (tick) begin
        pre_cnt <= '0;
        if (live == '0) active <= 1'b0;
        else            live   <= live - 1'b1;
      end else if (active) begin
        pre_cnt <= pre_cnt + 8'd1;
      end
    end
  end

endmodule

// File: rtl/wdt_chain_timer.sv
`timescale 1ns/1ps
module wdt_chain_timer
  import wdt_chain_pkg::*;
#(
  parameter int          NUM_CNT  = 2,
  parameter int          CNT_W    = 64,
  parameter int          ADDR_W   = 6,
  parameter int          WD_IDX   = 1,
  parameter logic [5:0]  SEL_ADDR = 6'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              rst_req
);

  localparam int SLOT_W = ADDR_W - 4;
  localparam int HI_W   = CNT_W - 32;

  logic [SLOT_W-1:0] slot;
  logic [3:0]        off;
  assign slot = bus_addr[ADDR_W-1:4];
  assign off  = bus_addr[3:0];

  cnt_cfg_t         cfg_a  [NUM_CNT];
  logic [CNT_W-1:0] live_a [NUM_CNT];
  logic [CNT_W-1:0] rel_a  [NUM_CNT];
  logic [NUM_CNT-1:0] en_a, act_a, end_a, trg_a, ctrl_we_a;
  logic [NUM_CNT-1:0] sel_q;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic prev;
    if (i == 0) begin : g_first
      assign prev = 1'b0;
    end else begin : g_chain
      assign prev = end_a[i-1];
    end
    assign ctrl_we_a[i] = bus_we && (slot == SLOT_W'(i)) && (off == 4'h0);

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_we    (ctrl_we_a[i]),
      .ctrl_wdata (bus_wdata[15:0]),
      .lo_we      (bus_we && (slot == SLOT_W'(i)) && (off == 4'h4)),
      .hi_we      (bus_we && (slot == SLOT_W'(i)) && (off == 4'h8)),
      .word_wdata (bus_wdata),
      .prev_end   (prev),
      .cfg        (cfg_a[i]),
      .en         (en_a[i]),
      .active     (act_a[i]),
      .live       (live_a[i]),
      .reload     (rel_a[i]),
      .end_evt    (end_a[i]),
      .trig_hit   (trg_a[i])
    );
  end

  // Named watchdog-side events for the checker.
  logic             wd_end, wd_active, wd_en, wd_trig, wd_ctrl_we;
  logic [CNT_W-1:0] wd_live, wd_reload;
  logic [13:0]      wd_cfg;
  assign wd_end     = end_a[WD_IDX];
  assign wd_active  = act_a[WD_IDX];
  assign wd_en      = en_a[WD_IDX];
  assign wd_trig    = trg_a[WD_IDX];
  assign wd_ctrl_we = ctrl_we_a[WD_IDX];
  assign wd_live    = live_a[WD_IDX];
  assign wd_reload  = rel_a[WD_IDX];
  assign wd_cfg     = cfg_a[WD_IDX];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= '0;
      rst_req <= 1'b0;
    end else begin
      if (bus_we && (bus_addr == SEL_ADDR[ADDR_W-1:0])) sel_q <= bus_wdata[NUM_CNT-1:0];
      rst_req <= wd_end && sel_q[WD_IDX];
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (slot == SLOT_W'(i)) begin
        case (off)
          4'h0:    bus_rdata = ctrl_image(cfg_a[i], act_a[i], en_a[i]);
          4'h4:    bus_rdata = live_a[i][31:0];
          4'h8:    bus_rdata = 32'(live_a[i][CNT_W-1:32]);
          default: bus_rdata = '0;
        endcase
      end
    end
    if (bus_addr == SEL_ADDR[ADDR_W-1:0]) bus_rdata = 32'(sel_q);
  end

endmodule

// File: rtl/wdt_chain_chk.sv
`timescale 1ns/1ps
module wdt_chain_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_req,
  input logic             wd_end,
  input logic             wd_active,
  input logic             wd_en,
  input logic             wd_trig,
  input logic             wd_ctrl_we,
  input logic [31:0]      bus_wdata,
  input logic [CNT_W-1:0] wd_live,
  input logic [CNT_W-1:0] wd_reload,
  input logic [13:0]      wd_cfg
);

  logic unused_chk;
  assign unused_chk = ^{wd_end, wd_en};

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  a_r9_counter_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !wd_active);

  a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_ctrl_we && !bus_wdata[0]) |=> !wd_active);

  a_r8_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_ctrl_we && wd_active) |=> $stable(wd_cfg));

  a_r5_trigger_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_trig && !(wd_ctrl_we && !bus_wdata[0])) |=> (wd_active && wd_live == $past(wd_reload)));

  a_r3_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_active && !wd_trig && !wd_ctrl_we) |=> $stable(wd_live));

endmodule

bind wdt_chain_timer wdt_chain_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_req    (rst_req),
  .wd_end     (wd_end),
  .wd_active  (wd_active),
  .wd_en      (wd_en),
  .wd_trig    (wd_trig),
  .wd_ctrl_we (wd_ctrl_we),
  .bus_wdata  (bus_wdata),
  .wd_live    (wd_live),
  .wd_reload  (wd_reload),
  .wd_cfg     (wd_cfg)
);

// File: tb/wdt_chain_timer_tb.sv
`timescale 1ns/1ps
module wdt_chain_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req;

  int total = 0;
  int bad = 0;
  int n_rst = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  wdt_chain_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  // ---------------- behavioural reference model ----------------
  logic [63:0] m_rel [2];
  logic [63:0] m_live[2];
  int          m_pre [2];
  bit          m_act [2], m_en[2];
  bit   [1:0]  m_mode[2];
  bit   [3:0]  m_trg [2];
  bit   [7:0]  m_psc [2];
  bit   [1:0]  m_sel;
  bit          m_rst;
  bit          tk[2], endv[2], trg[2];
  bit          cw, st;
  bit   [1:0]  nm;
  logic [63:0] oldrel;
  int          per;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_rel[i] = '0; m_live[i] = '0; m_pre[i] = 0; m_act[i] = 0; m_en[i] = 0;
        m_mode[i] = 0; m_trg[i] = 0; m_psc[i] = 0;
      end
      m_sel = 0; m_rst = 0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        per = (m_psc[i] < 2) ? 2 : int'(m_psc[i]);
        tk[i]   = m_act[i] && (m_pre[i] == per - 1);
        endv[i] = tk[i] && (m_live[i] == 0);
      end
      trg[0] = 0;
      trg[1] = m_en[1] && m_mode[1] == 2'b11 && m_trg[1] == 4'h5 && endv[0];
      m_rst = endv[1] && m_sel[1];
      for (int i = 0; i < 2; i++) begin
        cw = bus_we && (bus_addr == 6'(i * 16));
        nm = (cw && !m_act[i]) ? bus_wdata[3:2] : m_mode[i];
        st = (cw && bus_wdata[0] && !m_en[i] && nm != 2'b11) || trg[i];
        oldrel = m_rel[i];
        if (cw) begin
          m_en[i] = bus_wdata[0];
          if (!m_act[i]) begin
            m_mode[i] = bus_wdata[3:2]; m_trg[i] = bus_wdata[7:4]; m_psc[i] = bus_wdata[15:8];
          end
        end
        if (bus_we && bus_addr == 6'(i * 16 + 4)) m_rel[i][31:0]  = bus_wdata;
        if (bus_we && bus_addr == 6'(i * 16 + 8)) m_rel[i][63:32] = bus_wdata;
        if (cw && !bus_wdata[0]) m_act[i] = 0;
        else if (st) begin m_act[i] = 1; m_live[i] = oldrel; m_pre[i] = 0; end
        else if (tk[i]) begin
          m_pre[i] = 0;
          if (m_live[i] == 0) m_act[i] = 0; else m_live[i] = m_live[i] - 1;
        end else if (m_act[i]) m_pre[i] = m_pre[i] + 1;
      end
      if (bus_we && bus_addr == 6'h20) m_sel = bus_wdata[1:0];
    end
  end

  function automatic logic [31:0] m_read(input logic [5:0] a);
    for (int i = 0; i < 2; i++) begin
      if (a == 6'(i * 16))     return {16'h0, m_psc[i], m_trg[i], m_mode[i], m_act[i], m_en[i]};
      if (a == 6'(i * 16 + 4)) return m_live[i][31:0];
      if (a == 6'(i * 16 + 8)) return m_live[i][63:32];
    end
    if (a == 6'h20) return {30'h0, m_sel};
    return '0;
  endfunction

  // ---------------- checking ----------------
  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R9 rst_req vs model", 64'(rst_req), 64'(m_rst));
      if (rst_req) n_rst++;
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string req);
    bus_addr = a;
    #1;
    check(req, 64'(bus_rdata), 64'(exp));
    check({req, " model"}, 64'(bus_rdata), 64'(m_read(a)));
  endtask

  initial begin
    #800000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  int base;

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R2: reset state
    rd(6'h00, 32'h0, "R2 ctrl0 reset");
    rd(6'h10, 32'h0, "R2 ctrl1 reset");
    rd(6'h20, 32'h0, "R1 sel reset");
    check("R9 no request after reset", 64'(rst_req), 64'h0);

    // R3/R4: one-shot, reload 3, prescale 4 -> ends 16 clocks after start
    wr(6'h04, 32'd3);
    wr(6'h00, 32'h0000_0401);
    rd(6'h00, 32'h0000_0403, "R3 active after enable");
    idle(15);
    rd(6'h04, 32'd0, "R4 count at zero before end");
    rd(6'h00, 32'h0000_0403, "R4 still active at 15");
    idle(1);
    rd(6'h00, 32'h0000_0401, "R3 active cleared at end");

    // R1: high word and borrow across words
    wr(6'h08, 32'd1);
    wr(6'h04, 32'd0);
    wr(6'h00, 32'h0000_0000);
    wr(6'h00, 32'h0000_0201);
    rd(6'h08, 32'd1, "R1 high word loaded");
    rd(6'h04, 32'd0, "R1 low word loaded");
    idle(2);
    rd(6'h08, 32'd0, "R1 high word after borrow");
    rd(6'h04, 32'hFFFF_FFFF, "R1 low word after borrow");
    // R7: disable freezes
    wr(6'h00, 32'h0000_0200);
    rd(6'h00, 32'h0000_0200, "R7 active cleared by disable");
    idle(5);
    rd(6'h04, 32'hFFFF_FFFF, "R7 count frozen");

    // Watchdog chain set-up
    wr(6'h08, 32'd0);
    wr(6'h04, 32'd0);
    wr(6'h14, 32'd20);
    wr(6'h18, 32'd0);
    wr(6'h10, 32'h0000_035D);
    idle(10);
    rd(6'h10, 32'h0000_035D, "R5 enable alone does not start");
    wr(6'h20, 32'h2);
    rd(6'h20, 32'h2, "R1 select readback");
    wr(6'h00, 32'h0000_0201);
    idle(3);
    rd(6'h10, 32'h0000_035F, "R6 chained trigger started watchdog");
    wr(6'h10, 32'h0000_0801);
    rd(6'h10, 32'h0000_035F, "R8 config locked while active");

    // R10: regular refresh prevents expiry
    base = n_rst;
    for (int k = 0; k < 5; k++) begin
      wr(6'h00, 32'h0000_0200);
      wr(6'h00, 32'h0000_0201);
      idle(30);
    end
    check("R10 no request while refreshed", 64'(n_rst - base), 64'd0);
    idle(100);
    check("R9 one request after expiry", 64'(n_rst - base), 64'd1);
    rd(6'h10, 32'h0000_035D, "R9 watchdog stopped after expiry");

    // R9: role bit clear -> no request
    wr(6'h20, 32'h0);
    base = n_rst;
    wr(6'h00, 32'h0000_0200);
    wr(6'h00, 32'h0000_0201);
    idle(100);
    check("R9 no request without role", 64'(n_rst - base), 64'd0);

    // R11: reload 0 expires at the first tick after trigger
    wr(6'h14, 32'd0);
    wr(6'h20, 32'h2);
    wr(6'h00, 32'h0000_0200);
    wr(6'h00, 32'h0000_0201);
    idle(4);
    check("R11 no request before first tick", 64'(rst_req), 64'd0);
    idle(1);
    check("R11 request at first tick", 64'(rst_req), 64'd1);
    idle(1);
    check("R9 request lasts one cycle", 64'(rst_req), 64'd0);

    idle(5);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule